// File: doc/BRIEF.md
# Real-Time Clock I/O Peripheral

This block is a programmable clock for the I/O bus of a 12-bit processor. An external tick input advances a count register while the clock is enabled. When the count passes a terminal value it returns to zero, the value it reached is captured into an output buffer, and an event flag is raised. Software controls the block with one-cycle I/O commands on device code 13 (octal). Each command returns skip, accumulator-clear and read data in the same cycle. An interrupt request is raised when the event flag and the interrupt enable are both set.

Enabling the clock starts a mask window of a set number of system clock cycles. During the window the count still advances, but no event can raise the flag. A capture that falls in the same cycle as a buffer read is dropped, so a read never returns a value that is changing.

Top module: `rtc_iot`

## Requirements
- R1: Command 2 (pulse_i=3'b010 on dev_i=6'o13 with iot_valid_i high) clears the flag, the flag buffer, the clock enable and the interrupt enable. After it, ticks no longer advance the count and no event occurs.
- R2: While the clock is enabled, each tick_i pulse adds one to the count. The tick that finds the count at TERM is the overflow: it reloads the count to 0 and raises the flag. From a count of 0, the flag rises on the TERM+1-th tick.
- R3: Command 3 (pulse_i=3'b011) drives skip_o high in its own cycle only if the flag is set, and then clears the flag. With the flag clear, it gives no skip and changes nothing.
- R4: Command 4 (pulse_i=3'b100) drives ac_clr_o high and places the output buffer, zero-extended, on rd_data_o in the same cycle. In every other cycle ac_clr_o and rd_data_o are 0.
- R5: An overflow captures the count it reached (TERM) into the output buffer. The capture is suppressed when the overflow falls in a command-4 cycle.
- R6: Command 6 (pulse_i=3'b110) clears all control state and then sets only the clock enable, so irq_o stays low.
- R7: Command 7 (pulse_i=3'b111) clears all control state and then sets both the clock enable and the interrupt enable. irq_o is high exactly while the flag and the interrupt enable are both set.
- R8: For MASK_CYCLES cycles after command 6 or 7, an overflow still reloads the count but does not raise the flag.
- R9: flag_buf_o rises whenever the flag is raised. It is cleared only by commands 2, 6 and 7; command 3 leaves it set.
- R10: Commands on other device codes, and pulse codes 0, 1 and 5 on device 13, change no state and drive no response.
- R11: After reset, the count, buffer, flag, flag buffer and both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse from the clock source |
| iot_valid_i | input | 1 | I/O command strobe, one cycle per command |
| dev_i | input | 6 | Device code of the command |
| pulse_i | input | 3 | Pulse bits: bit0 = pulse 1, bit1 = pulse 2, bit2 = pulse 4 |
| skip_o | output | 1 | Skip response |
| irq_o | output | 1 | Interrupt request |
| ac_clr_o | output | 1 | Accumulator clear during a buffer read |
| rd_data_o | output | DATA_W | Output buffer during a read, else 0 |
| flag_buf_o | output | 1 | Flag buffer state |

## Verification
The assertions assume that tick_i and each command are single-cycle pulses synchronous to clk_i, and that at most one command arrives per cycle. The stimulus drives every input one cycle at a time from the falling edge, and it never sends more than one command in a cycle. Directed sequences walk the count to exactly TERM so that an overflow lands inside the mask window and in the same cycle as a read. Seeded random ticks and commands, including foreign device codes and unused pulse codes, are then compared against a cycle model in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [5:0] RTC_DEV = 6'o13;

  typedef struct packed {
    logic clr_all;
    logic set_en;
    logic set_ie;
    logic skip;
    logic read;
  } rtc_cmd_t;
endpackage

// File: rtl/rtc_decode.sv
module rtc_decode
  import rtc_pkg::*;
(
  input  logic       valid_i,
  input  logic [5:0] dev_i,
  input  logic [2:0] pulse_i,
  output rtc_cmd_t   cmd_o
);
  logic hit;
  assign hit = valid_i && (dev_i == RTC_DEV);

  always_comb begin
    cmd_o         = '0;
    cmd_o.clr_all = hit && ((pulse_i == 3'b010) || (pulse_i[2:1] == 2'b11));
    cmd_o.set_en  = hit && (pulse_i[2:1] == 2'b11);
    cmd_o.set_ie  = hit && (pulse_i == 3'b111);
    cmd_o.skip    = hit && (pulse_i == 3'b011);
    cmd_o.read    = hit && (pulse_i == 3'b100);
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CNT_W = 12,
  parameter int TERM  = (1 << CNT_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             rd_i,
  output logic             ovf_o,
  output logic [CNT_W-1:0] cap_o
);
  localparam logic [CNT_W-1:0] TERM_V = CNT_W'(TERM);

  logic [CNT_W-1:0] cnt_q, cap_q;

  assign ovf_o = tick_i && en_i && (cnt_q == TERM_V);
  assign cap_o = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cap_q <= '0;
    end else begin
      if (tick_i && en_i) cnt_q <= ovf_o ? '0 : cnt_q + 1'b1;
      if (ovf_o && !rd_i) cap_q <= cnt_q;  // no capture under a read
    end
  end

  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i && cnt_q == TERM_V) |=> (cnt_q == '0));
  assert_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TERM_V);
  assert_frozen_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == $past(cnt_q)));
  assert_no_tear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && rd_i) |=> $stable(cap_q));
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int MASK_CYCLES = 80
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  rtc_cmd_t cmd_i,
  input  logic     ovf_i,
  output logic     en_o,
  output logic     skip_o,
  output logic     irq_o,
  output logic     flag_buf_o
);
  localparam int MASK_W = (MASK_CYCLES < 2) ? 1 : $clog2(MASK_CYCLES + 1);
  localparam logic [MASK_W-1:0] MASK_V = MASK_W'(MASK_CYCLES);

  logic              flag_q, fbuf_q, en_q, ie_q;
  logic [MASK_W-1:0] mask_q;
  logic              set_ok;

  assign set_ok     = ovf_i && (mask_q == '0) && !cmd_i.clr_all;
  assign skip_o     = cmd_i.skip && flag_q;
  assign irq_o      = flag_q && ie_q;
  assign en_o       = en_q;
  assign flag_buf_o = fbuf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      fbuf_q <= 1'b0;
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      mask_q <= '0;
    end else begin
      if (cmd_i.clr_all) begin
        flag_q <= 1'b0;
        fbuf_q <= 1'b0;
        en_q   <= cmd_i.set_en;
        ie_q   <= cmd_i.set_ie;
      end else begin
        flag_q <= (flag_q && !cmd_i.skip) || set_ok;  // new event wins over skip
        fbuf_q <= fbuf_q || set_ok;
      end
      if (cmd_i.set_en)       mask_q <= MASK_V;
      else if (mask_q != '0)  mask_q <= mask_q - 1'b1;
    end
  end

  assert_skip_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_o && !ovf_i) |=> !flag_q);
  assert_clear_all_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.clr_all |=> (!flag_q && !fbuf_q));
  assert_no_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.clr_all && !cmd_i.set_ie) |=> !irq_o);
  assert_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> ($past(mask_q) == '0));
  assert_fbuf_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |-> fbuf_q);
endmodule

// File: rtl/rtc_iot.sv
module rtc_iot
  import rtc_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CNT_W       = 12,
  parameter int TERM        = (1 << CNT_W) - 1,
  parameter int MASK_CYCLES = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              iot_valid_i,
  input  logic [5:0]        dev_i,
  input  logic [2:0]        pulse_i,
  output logic              skip_o,
  output logic              irq_o,
  output logic              ac_clr_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              flag_buf_o
);
  rtc_cmd_t         cmd;
  logic             en, ovf;
  logic [CNT_W-1:0] cap;

  rtc_decode u_decode (
    .valid_i (iot_valid_i),
    .dev_i   (dev_i),
    .pulse_i (pulse_i),
    .cmd_o   (cmd)
  );

  rtc_counter #(.CNT_W(CNT_W), .TERM(TERM)) u_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .en_i   (en),
    .rd_i   (cmd.read),
    .ovf_o  (ovf),
    .cap_o  (cap)
  );

  rtc_ctrl #(.MASK_CYCLES(MASK_CYCLES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .ovf_i      (ovf),
    .en_o       (en),
    .skip_o     (skip_o),
    .irq_o      (irq_o),
    .flag_buf_o (flag_buf_o)
  );

  assign ac_clr_o = cmd.read;

  generate
    if (DATA_W > CNT_W) begin : g_pad
      assign rd_data_o = cmd.read ? {{(DATA_W-CNT_W){1'b0}}, cap} : '0;
    end else begin : g_trim
      assign rd_data_o = cmd.read ? cap[DATA_W-1:0] : '0;
    end
  endgenerate

  assert_read_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ac_clr_o |-> (rd_data_o == '0));
endmodule

// File: tb/rtc_iot_tb.sv
`timescale 1ns/1ps
module rtc_iot_tb;
  localparam int TERM = 9;
  localparam int MASK = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick = 1'b0, valid = 1'b0;
  logic [5:0]  dev = '0;
  logic [2:0]  pulse = '0;
  logic        skip, irq, ac_clr, fbuf;
  logic [11:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model state
  int m_cnt = 0, m_cap = 0, m_mask = 0;
  bit m_flag = 0, m_fb = 0, m_en = 0, m_ie = 0;

  always #2.5 clk = ~clk;

  rtc_iot #(.DATA_W(12), .CNT_W(4), .TERM(TERM), .MASK_CYCLES(MASK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .iot_valid_i(valid),
    .dev_i(dev), .pulse_i(pulse), .skip_o(skip), .irq_o(irq),
    .ac_clr_o(ac_clr), .rd_data_o(rd_data), .flag_buf_o(fbuf));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_rd(bit rd, int cap);
    return rd ? cap : 0;
  endfunction

  // one cycle: drive, check combinational response, advance model
  task automatic step(bit t, bit v, logic [5:0] d, logic [2:0] p);
    bit hit, clr, sk, rd, ovf, set;
    @(negedge clk);
    tick = t; valid = v; dev = d; pulse = p;
    #1;
    hit = v && d == 6'o13;
    clr = hit && (p == 3'd2 || p == 3'd6 || p == 3'd7);
    sk  = hit && p == 3'd3;
    rd  = hit && p == 3'd4;
    chk("R3 skip", skip, sk && m_flag);
    chk("R4 ac_clr", ac_clr, rd);
    chk("R4 rd_data", rd_data, exp_rd(rd, m_cap));
    chk("R7 irq", irq, m_flag && m_ie);
    chk("R9 flag_buf", fbuf, m_fb);
    ovf = t && m_en && m_cnt == TERM;
    set = ovf && m_mask == 0 && !clr;
    if (t && m_en) m_cnt = ovf ? 0 : m_cnt + 1;
    if (ovf && !rd) m_cap = TERM;
    if (clr) begin
      m_flag = 0; m_fb = 0;
      m_en = (p != 3'd2); m_ie = (p == 3'd7);
    end else begin
      m_flag = (m_flag && !sk) || set;
      m_fb = m_fb || set;
    end
    if (clr && p != 3'd2) m_mask = MASK;
    else if (m_mask != 0) m_mask--;
  endtask

  task automatic cmd(logic [2:0] p);
    step(1'b0, 1'b1, 6'o13, p);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 6'o0, 3'd0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 6'o0, 3'd0);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    chk("R11 irq", irq, 0);
    chk("R11 flag_buf", fbuf, 0);
    rst_n = 1'b1;
    cmd(3'd4);  // read returns zero buffer
    cmd(3'd3);  // no skip
    ticks(TERM + 3);  // clock disabled after reset
    cmd(3'd3);

    // R5: overflow coinciding with a read does not capture
    cmd(3'd6);
    idle(MASK + 1);
    while (m_cnt != TERM) ticks(1);
    step(1'b1, 1'b1, 6'o13, 3'd4);
    #2; chk("R5 suppressed capture", rd_data, 0);
    cmd(3'd4);
    chk("R6 no irq with enable only", irq, 0);
    cmd(3'd3);  // skip, clears flag

    // R2/R7: exact overflow tick count with interrupts
    cmd(3'd7);
    idle(MASK + 1);
    ticks(TERM);
    #2; chk("R2 no flag before overflow", irq, 0);
    ticks(1);
    #2; chk("R2 flag on overflow", irq, 1);
    chk("R7 irq asserted", irq, 1);
    step(1'b0, 1'b1, 6'o13, 3'd4);
    #0; chk("R5 captured value", m_cap, TERM);
    // R10: foreign device and unused codes
    step(1'b0, 1'b1, 6'o12, 3'd2);
    step(1'b0, 1'b1, 6'o13, 3'd5);
    step(1'b0, 1'b1, 6'o13, 3'd1);
    #2; chk("R10 ignored commands", irq, 1);
    cmd(3'd3);
    cmd(3'd3);
    #2; chk("R9 flag_buf held after skip", fbuf, 1);

    // R1: clear-all stops the clock
    cmd(3'd2);
    ticks(3 * (TERM + 1));
    cmd(3'd3);
    #2; chk("R1 no event after stop", fbuf, 0);

    // R8: overflow inside mask window
    cmd(3'd7);
    idle(MASK + 1);
    while (m_cnt != TERM) ticks(1);
    cmd(3'd7);
    ticks(1);
    #2; chk("R8 masked overflow", fbuf, 0);
    idle(MASK);
    ticks(TERM + 1);
    #2; chk("R8 flag after mask", irq, 1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      bit t = ($urandom % 2) == 0;
      bit v = ($urandom % 5) == 0;
      logic [5:0] d = (($urandom % 4) == 0) ? 6'($urandom) : 6'o13;
      logic [2:0] p = 3'($urandom);
      step(t, v, d, p);
    end
    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule